// File: doc/BRIEF.md
# Sleep Mode and Clock-Enable Controller

This block sets the power state of a small processor system. While the device runs, software programs a sleep-control register (an enable bit and a three-bit mode code) and a peripheral clock-stop register. When the CPU raises its one-cycle sleep strobe, the controller enters the programmed sleep mode, if that mode is valid. It then removes the clock enables for the CPU, the nonvolatile memory (NVM), the peripheral domains, the asynchronous timer domain and the main oscillator, each according to the mode.

During sleep the controller watches the interrupt-pending lines. Each mode allows only its own set of lines to wake the device. Once a wake is seen, the CPU is held for a fixed four cycles and then released. In the first running cycle a one-cycle wake pulse is raised.

If the NVM is still busy when sleep begins, its clock is kept until the operation ends. An asynchronous reset abandons any sleep state and clears every register. Entering or leaving sleep never changes the register contents.

Top module: `sleep_clk_ctrl`

## Requirements
- R1: While reset is held and just after it, the controller is running: `cpuHalt`=0, `wakePulse`=0, and every clock enable (CPU, NVM, all peripherals, async, oscillator) is 1, because both registers reset to zero.
- R2: A write with `regAddr`=0 sets sleep enable from bit 0 and the mode code from bits 3:1. A sleep strobe does nothing when sleep enable is 0, when the mode code is 1, 4 or 5 (reserved), or when the controller is not running.
- R3: In idle sleep (mode code 0), the CPU clock enable is 0, the NVM enable is 0 (subject to R8), and the async and oscillator enables are 1.
- R4: In idle sleep, any set bit of `irqPend` wakes the device.
- R5: In power-down (code 2), all peripheral, async and oscillator enables are 0. Only lines in ASYNC_MASK wake the device.
- R6: In power-save (code 3), the async enable is 1, while the peripheral and oscillator enables are 0. Lines in ASYNC_MASK or RTC_MASK wake the device.
- R7: Standby (code 6) keeps only the oscillator enabled and wakes on ASYNC_MASK lines. Extended standby (code 7) keeps the oscillator and async enables on and wakes on ASYNC_MASK or RTC_MASK lines.
- R8: If `nvmBusy` is 1 in the cycle the sleep strobe is accepted, the NVM enable stays 1 during sleep. It drops one cycle after `nvmBusy` is first seen low and then stays 0 until the wake.
- R9: `cpuHalt` rises in the cycle after an accepted sleep strobe. After the cycle in which a permitted interrupt is seen, it stays 1, with the CPU clock enable at 0, for exactly four more cycles.
- R10: `wakePulse` is 1 for exactly one cycle: the first cycle with `cpuHalt` at 0 after the four halt cycles.
- R11: Asserting `rstN` low during sleep returns all outputs at once to the R1 state.
- R12: A write with `regAddr`=1 loads the peripheral stop bits from bits NPER-1:0. Bit i set forces `perClkEn[i]` to 0 while running, during idle sleep and during the halt cycles.
- R13: The registers keep their values through sleep and wake, so a second sleep strobe after waking enters the same mode without any new write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = sleep control, 1 = peripheral stop bits |
| regWrData | input | RW | Write data (RW = max(4, NPER)) |
| sleepReq | input | 1 | One-cycle sleep request from the CPU |
| irqPend | input | NIRQ | Interrupt-pending lines |
| nvmBusy | input | 1 | NVM programming in progress |
| cpuClkEn | output | 1 | CPU clock enable |
| nvmClkEn | output | 1 | NVM clock enable |
| perClkEn | output | NPER | Per-peripheral clock enables |
| asyncClkEn | output | 1 | Asynchronous timer domain enable |
| oscEn | output | 1 | Main oscillator enable |
| cpuHalt | output | 1 | CPU held (sleep and post-wake stall) |
| wakePulse | output | 1 | One-cycle pulse when execution resumes |

## Verification
The hardest case to reach is the NVM hold: `nvmBusy` has to be high in the exact cycle the sleep strobe is taken. It then has to fall while the device is still asleep, in a mode that would otherwise cut the NVM clock. The stimulus raises `nvmBusy` before strobing into power-down, holds it for several sleep cycles, drops it, and only then presents a permitted wake line.

A second case is a reset that arrives mid-sleep. The bench pulses `rstN` while the controller sleeps in power-save. It also strobes sleep again during the halt window to show that such a strobe is ignored.

// File: rtl/sleep_pkg.sv
package sleep_pkg;

  typedef enum logic [1:0] {
    PH_ACTIVE = 2'd0,
    PH_SLEEP  = 2'd1,
    PH_HALT   = 2'd2
  } phase_e;

  localparam logic [2:0] MODE_IDLE  = 3'd0;
  localparam logic [2:0] MODE_PDOWN = 3'd2;
  localparam logic [2:0] MODE_PSAVE = 3'd3;
  localparam logic [2:0] MODE_STBY  = 3'd6;
  localparam logic [2:0] MODE_XSTBY = 3'd7;

  localparam int HALT_CYCLES = 4;

  typedef struct packed {
    logic   enter;
    logic   resume;
    phase_e phase;
  } ctlStrobe_t;

  function automatic logic modeValid(input logic [2:0] m);
    return (m == MODE_IDLE) || (m == MODE_PDOWN) || (m == MODE_PSAVE) ||
           (m == MODE_STBY) || (m == MODE_XSTBY);
  endfunction

endpackage

// File: rtl/sleep_datapath.sv
module sleep_datapath
  import sleep_pkg::*;
#(
  parameter int NIRQ = 8,
  parameter int NPER = 4,
  parameter logic [NIRQ-1:0] ASYNC_MASK = 8'h03,
  parameter logic [NIRQ-1:0] RTC_MASK = 8'h04,
  localparam int RW = (NPER > 4) ? NPER : 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic            regAddr,
  input  logic [RW-1:0]   regWrData,
  input  logic [NIRQ-1:0] irqPend,
  input  logic            nvmBusy,
  input  ctlStrobe_t      ctl,
  output logic            sleepOk,
  output logic            wakeHit,
  output logic            cpuClkEn,
  output logic            nvmClkEn,
  output logic [NPER-1:0] perClkEn,
  output logic            asyncClkEn,
  output logic            oscEn
);

  logic            sleepEn;
  logic [2:0]      modeField;
  logic [NPER-1:0] stopBits;
  logic [2:0]      sleptMode;
  logic            nvmHold;
  logic [NIRQ-1:0] wakeMask;
  logic            perDomainOn;
  logic            inSleep;

  assign inSleep = (ctl.phase == PH_SLEEP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleepEn   <= 1'b0;
      modeField <= 3'd0;
      stopBits  <= '0;
    end else if (regWrEn) begin
      if (regAddr == 1'b0) begin
        sleepEn   <= regWrData[0];
        modeField <= regWrData[3:1];
      end else begin
        stopBits  <= regWrData[NPER-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sleptMode <= MODE_IDLE;
      nvmHold   <= 1'b0;
    end else if (ctl.enter) begin
      sleptMode <= modeField;
      nvmHold   <= nvmBusy;
    end else if (inSleep) begin
      nvmHold   <= nvmHold & nvmBusy;
    end
  end

  assign sleepOk = sleepEn && modeValid(modeField);

  always_comb begin
    unique case (sleptMode)
      MODE_IDLE:             wakeMask = '1;
      MODE_PSAVE, MODE_XSTBY: wakeMask = ASYNC_MASK | RTC_MASK;
      default:               wakeMask = ASYNC_MASK;
    endcase
  end

  assign wakeHit = inSleep && ((irqPend & wakeMask) != '0);

  always_comb begin
    cpuClkEn    = (ctl.phase == PH_ACTIVE);
    nvmClkEn    = 1'b1;
    asyncClkEn  = 1'b1;
    oscEn       = 1'b1;
    perDomainOn = 1'b1;
    if (inSleep) begin
      nvmClkEn    = nvmHold;
      perDomainOn = (sleptMode == MODE_IDLE);
      asyncClkEn  = (sleptMode == MODE_IDLE) || (sleptMode == MODE_PSAVE) ||
                    (sleptMode == MODE_XSTBY);
      oscEn       = (sleptMode == MODE_IDLE) || (sleptMode == MODE_STBY) ||
                    (sleptMode == MODE_XSTBY);
    end
  end

  for (genvar i = 0; i < NPER; i++) begin : g_perGate
    assign perClkEn[i] = perDomainOn & ~stopBits[i];
  end

endmodule

// File: rtl/sleep_control.sv
module sleep_control
  import sleep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       sleepOk,
  input  logic       wakeHit,
  output ctlStrobe_t ctl,
  output logic       cpuHalt,
  output logic       wakePulse
);

  localparam int HCW = $clog2(HALT_CYCLES);
  localparam logic [HCW-1:0] HALT_LAST = HCW'(HALT_CYCLES - 1);

  phase_e         phase;
  logic [HCW-1:0] haltCnt;

  always_comb begin
    ctl.phase  = phase;
    ctl.enter  = (phase == PH_ACTIVE) && sleepReq && sleepOk;
    ctl.resume = (phase == PH_HALT) && (haltCnt == HALT_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_ACTIVE;
      haltCnt   <= '0;
      wakePulse <= 1'b0;
    end else begin
      wakePulse <= ctl.resume;
      unique case (phase)
        PH_ACTIVE: if (ctl.enter) phase <= PH_SLEEP;
        PH_SLEEP: if (wakeHit) begin
          phase   <= PH_HALT;
          haltCnt <= '0;
        end
        PH_HALT: begin
          if (ctl.resume) phase <= PH_ACTIVE;
          else haltCnt <= haltCnt + 1'b1;
        end
        default: phase <= PH_ACTIVE;
      endcase
    end
  end

  assign cpuHalt = (phase != PH_ACTIVE);

endmodule

// File: rtl/sleep_clk_ctrl.sv
module sleep_clk_ctrl
  import sleep_pkg::*;
#(
  parameter int NIRQ = 8,
  parameter int NPER = 4,
  parameter logic [NIRQ-1:0] ASYNC_MASK = 8'h03,
  parameter logic [NIRQ-1:0] RTC_MASK = 8'h04,
  localparam int RW = (NPER > 4) ? NPER : 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrEn,
  input  logic            regAddr,
  input  logic [RW-1:0]   regWrData,
  input  logic            sleepReq,
  input  logic [NIRQ-1:0] irqPend,
  input  logic            nvmBusy,
  output logic            cpuClkEn,
  output logic            nvmClkEn,
  output logic [NPER-1:0] perClkEn,
  output logic            asyncClkEn,
  output logic            oscEn,
  output logic            cpuHalt,
  output logic            wakePulse
);

  ctlStrobe_t ctl;
  logic       sleepOk;
  logic       wakeHit;

  sleep_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sleepReq  (sleepReq),
    .sleepOk   (sleepOk),
    .wakeHit   (wakeHit),
    .ctl       (ctl),
    .cpuHalt   (cpuHalt),
    .wakePulse (wakePulse)
  );

  sleep_datapath #(
    .NIRQ(NIRQ), .NPER(NPER), .ASYNC_MASK(ASYNC_MASK), .RTC_MASK(RTC_MASK)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .irqPend    (irqPend),
    .nvmBusy    (nvmBusy),
    .ctl        (ctl),
    .sleepOk    (sleepOk),
    .wakeHit    (wakeHit),
    .cpuClkEn   (cpuClkEn),
    .nvmClkEn   (nvmClkEn),
    .perClkEn   (perClkEn),
    .asyncClkEn (asyncClkEn),
    .oscEn      (oscEn)
  );

endmodule

// File: rtl/sleep_clk_ctrl_chk.sv
module sleep_clk_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic sleepReq,
  input logic nvmBusy,
  input logic cpuClkEn,
  input logic nvmClkEn,
  input logic cpuHalt,
  input logic wakePulse
);

  // R1: running means the CPU clock is enabled
  a_r1_run_cpu_on: assert property (@(posedge clk) disable iff (!rstN)
    !cpuHalt |-> cpuClkEn);

  // R9: the CPU clock is off whenever the CPU is held
  a_r9_halt_cpu_off: assert property (@(posedge clk) disable iff (!rstN)
    cpuHalt |-> !cpuClkEn);

  // R2: no sleep without a request
  a_r2_no_spont_sleep: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuHalt && !sleepReq) |=> !cpuHalt);

  // R9: release comes only after one sleep cycle plus four halt cycles
  a_r9_halt_length: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuHalt) |-> ($past(cpuHalt, 2) && $past(cpuHalt, 3) &&
                        $past(cpuHalt, 4) && $past(cpuHalt, 5)));

  // R10: the wake pulse lasts one cycle
  a_r10_pulse_single: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |=> !wakePulse);

  // R10: the wake pulse marks the end of the halt
  a_r10_pulse_at_release: assert property (@(posedge clk) disable iff (!rstN)
    wakePulse |-> (!cpuHalt && $past(cpuHalt)));

  // R8: the NVM clock is never cut while the NVM was busy
  a_r8_nvm_hold: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nvmClkEn) |-> !$past(nvmBusy));

endmodule

bind sleep_clk_ctrl sleep_clk_ctrl_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sleepReq  (sleepReq),
  .nvmBusy   (nvmBusy),
  .cpuClkEn  (cpuClkEn),
  .nvmClkEn  (nvmClkEn),
  .cpuHalt   (cpuHalt),
  .wakePulse (wakePulse)
);

// File: tb/tb_sleep_clk_ctrl.sv
`timescale 1ns/1ps
module tb_sleep_clk_ctrl;

  localparam int NIRQ = 8;
  localparam int NPER = 4;
  localparam int OW = NPER + 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic regAddr = 1'b0;
  logic [3:0] regWrData = '0;
  logic sleepReq = 1'b0;
  logic [NIRQ-1:0] irqPend = '0;
  logic nvmBusy = 1'b0;
  logic cpuClkEn, nvmClkEn, asyncClkEn, oscEn, cpuHalt, wakePulse;
  logic [NPER-1:0] perClkEn;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  always #10 clk = ~clk;

  sleep_clk_ctrl dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .sleepReq(sleepReq), .irqPend(irqPend),
    .nvmBusy(nvmBusy), .cpuClkEn(cpuClkEn), .nvmClkEn(nvmClkEn),
    .perClkEn(perClkEn), .asyncClkEn(asyncClkEn), .oscEn(oscEn),
    .cpuHalt(cpuHalt), .wakePulse(wakePulse)
  );

  // behavioural reference: 0 running, 1 asleep, 2 halted after wake
  int mState, mCnt, mMode;
  bit mHold, mPulse, mEn;
  int mModeReg;
  logic [NPER-1:0] mStop;

  function automatic logic [NIRQ-1:0] allowFor(int m);
    if (m == 0) return 8'hFF;
    if (m == 3 || m == 7) return 8'h07;
    return 8'h03;
  endfunction

  function automatic bit okMode(int m);
    return (m == 0 || m == 2 || m == 3 || m == 6 || m == 7);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mCnt = 0; mMode = 0; mHold = 0; mPulse = 0;
      mEn = 0; mModeReg = 0; mStop = '0;
    end else begin
      bit nextPulse;
      nextPulse = 0;
      case (mState)
        0: if (sleepReq && mEn && okMode(mModeReg)) begin
             mState = 1; mMode = mModeReg; mHold = nvmBusy;
           end
        1: begin
             if ((irqPend & allowFor(mMode)) != 0) begin mState = 2; mCnt = 0; end
             mHold = mHold && nvmBusy;
           end
        default: if (mCnt == 3) begin mState = 0; nextPulse = 1; end
                 else mCnt = mCnt + 1;
      endcase
      mPulse = nextPulse;
      if (regWrEn) begin
        if (!regAddr) begin mEn = regWrData[0]; mModeReg = int'(regWrData[3:1]); end
        else mStop = regWrData[NPER-1:0];
      end
    end
  end

  function automatic logic [OW-1:0] expected();
    bit asleep, perOn;
    logic [NPER-1:0] per;
    asleep = (mState == 1);
    perOn = !asleep || mMode == 0;
    per = perOn ? ~mStop : '0;
    return {mState == 0, !asleep || mHold, per,
            !asleep || mMode == 0 || mMode == 3 || mMode == 7,
            !asleep || mMode == 0 || mMode == 6 || mMode == 7,
            mState != 0, mPulse};
  endfunction

  task automatic compare();
    logic [OW-1:0] got;
    logic [OW-1:0] exp;
    got = {cpuClkEn, nvmClkEn, perClkEn, asyncClkEn, oscEn, cpuHalt, wakePulse};
    exp = expected();
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: outputs got %b expected %b at %0t", curReq, got, exp, $time);
    end
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
    end
  endtask

  task automatic wr(bit a, logic [3:0] d);
    regWrEn = 1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 0;
  endtask

  task automatic goSleep();
    sleepReq = 1; tick(); sleepReq = 0;
  endtask

  task automatic wake(logic [NIRQ-1:0] v);
    irqPend = v; tick(); irqPend = '0; tick(6);
  endtask

  function automatic logic [3:0] ctlWord(int m, bit en);
    return {m[2:0], en};
  endfunction

  initial begin
    @(negedge clk); compare();
    tick(2);
    rstN = 1;
    curReq = "R1"; tick(2);

    curReq = "R2"; goSleep(); tick();        // sleep enable clear
    wr(0, ctlWord(1, 1)); goSleep(); tick(); // reserved code 1
    wr(0, ctlWord(4, 1)); goSleep(); tick(); // reserved code 4
    wr(0, ctlWord(5, 1)); goSleep(); tick(); // reserved code 5

    curReq = "R12"; wr(1, 4'b0101); tick();
    curReq = "R3"; wr(0, ctlWord(0, 1)); goSleep(); tick(3);
    curReq = "R4"; wake(8'h80);
    curReq = "R9"; goSleep(); tick(2); wake(8'h10);

    curReq = "R5"; wr(0, ctlWord(2, 1)); goSleep(); tick(2);
    irqPend = 8'h04; tick(3); irqPend = 8'h80; tick(3); wake(8'h02);

    curReq = "R6"; wr(0, ctlWord(3, 1)); goSleep(); tick(2);
    irqPend = 8'h80; tick(3); wake(8'h04);

    curReq = "R7"; wr(0, ctlWord(6, 1)); goSleep(); tick(2);
    irqPend = 8'h04; tick(3); wake(8'h01);
    wr(0, ctlWord(7, 1)); goSleep(); tick(2); wake(8'h04);

    curReq = "R8"; wr(0, ctlWord(2, 1)); nvmBusy = 1; goSleep(); tick(3);
    nvmBusy = 0; tick(3); nvmBusy = 1; tick(2); nvmBusy = 0; wake(8'h01);

    curReq = "R2"; goSleep(); tick(); irqPend = 8'h01; tick(); irqPend = '0;
    sleepReq = 1; tick(); sleepReq = 0; tick(6);

    curReq = "R13"; goSleep(); tick(2); wake(8'h02);

    curReq = "R10"; wr(0, ctlWord(0, 1)); goSleep(); wake(8'h40);

    curReq = "R11"; wr(0, ctlWord(3, 1)); goSleep(); tick(2);
    rstN = 0; #1; compare(); tick(2); rstN = 1; tick(3);
    curReq = "R2"; goSleep(); tick(2);       // enable cleared by reset

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule